// File: doc/BRIEF.md
# Double-Shift Left Datapath Unit

This unit shifts a 64-bit source word left by a count taken from a second operand, and instead of losing bits at either end it keeps them. The vacated low positions of the result take the low bits of a third, fill operand, and the bits pushed past the top of the word come back right-aligned in a second output, the spill word. A nonzero spill raises an overflow flag.

Both outputs come from one left rotate of the source, split by a mask of the upper bit positions. Because the spill of one unit has exactly the shape a fill operand needs, words can be passed from the least to the most significant through the unit to shift values wider than one word. When the record input is set, the unit also produces a four-bit condition field for the primary result, together with a write-enable for it.

An optional output register, selected by a parameter, captures every output when the input valid strobe is high. It presents them one cycle later with an output valid flag.

Top module: `dshl_unit`

## Requirements
- R1: The shift count n is the value of the low six bits of `amt_i` (0 to 63); changing any of the upper 58 bits of `amt_i` leaves every output unchanged.
- R2: `res_o` equals `src_i` shifted left by n with zeros entering, ORed with the low n bits of `fill_i` in its low n positions.
- R3: `spill_o` holds the n most significant bits of `src_i` in its bits n-1..0, and zeros in all other bits.
- R4: `ovf_o` is 1 exactly when `spill_o` is nonzero.
- R5: With n equal to 0, `res_o` equals `src_i`, `spill_o` is zero and `ovf_o` is 0, whatever `fill_i` holds.
- R6: With `rec_i` at 1, `cr_we_o` is 1 and `cr_o` is {neg, pos, zero, ovf}. In this encoding bit 3 is set when `res_o` read as a signed 64-bit value is negative, bit 2 when it is positive, bit 1 when it is zero, and bit 0 repeats `ovf_o`.
- R7: With `rec_i` at 0, `cr_we_o` is 0 and `cr_o` is 4'b0000.
- R8: With the output register in place (default), all outputs are captured at a clock edge where `in_valid_i` is 1. `out_valid_o` is 1 for the cycle after that edge. After an edge where `in_valid_i` is 0, `out_valid_o` is 0 and the data outputs keep their previous values.
- R9: A clock edge with `rst_n` low clears `out_valid_o` and all registered outputs to zero.
- R10: For a 128-bit value, shift the low word first, then feed its `spill_o` as the `fill_i` of the high word. The two results then form the 128-bit value shifted left by n with the outside fill in its low n bits, and the high word's spill holds the bits pushed out of the 128-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid_i | input | 1 | Operands valid; capture strobe |
| src_i | input | 64 | Word to be shifted |
| amt_i | input | 64 | Shift-amount operand; low six bits used |
| fill_i | input | 64 | Word whose low bits fill the vacated positions |
| rec_i | input | 1 | Record form: produce the condition field |
| res_o | output | 64 | Primary shifted result |
| spill_o | output | 64 | Bits shifted out of the top, right-aligned |
| ovf_o | output | 1 | Spill is nonzero |
| cr_o | output | 4 | Condition field {neg, pos, zero, ovf} |
| cr_we_o | output | 1 | Condition field write-enable |
| out_valid_o | output | 1 | Outputs hold a captured result |

## Verification
Every shift count from 0 to 63 is swept against several source and fill pairs: all ones, a lone top bit, alternating bit patterns and generated pseudo-random words. The lone top bit shows whether the spill is right-aligned and whether overflow follows it. All ones with a zero fill separates the masked fill from the shifted source at each count. The pseudo-random words carry garbage in the upper amount bits, which exposes any use of those bits, and record form alternates between transactions so that the sign, zero and write-enable encodings are all reached. A two-word chained shift compares against a 128-bit shift computed in the bench, and idle cycles with changing operands test that the register holds.

// File: rtl/dshl_pkg.sv
// Package: shared widths and the condition-field layout for the
// double-shift left unit. Assumes a power-of-two word width.
package dshl_pkg;

    // Condition field produced in record form; bit order is fixed
    // because the consumer decodes it as {neg, pos, zero, ovf}.
    typedef struct packed {
        logic neg;
        logic pos;
        logic zero;
        logic ovf;
    } dshl_cr_t;

    localparam int CR_W = $bits(dshl_cr_t);

endpackage

// File: rtl/dshl_rotator.sv
// Module: logarithmic left rotator.
// Rotates data_i left by n_i positions in SHW stages, where stage s
// rotates by 2**s when n_i[s] is set. Assumes W == 2**SHW.
module dshl_rotator #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   data_i,
    input  logic [SHW-1:0] n_i,
    output logic [W-1:0]   rot_o
);

    logic [W-1:0] stage [SHW+1];

    assign stage[0] = data_i;

    // One conditional power-of-two rotate per bit of the count.
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = n_i[s]
            ? {stage[s][W-STEP-1:0], stage[s][W-1:W-STEP]}
            : stage[s];
    end

    assign rot_o = stage[SHW];

endmodule

// File: rtl/dshl_mask_gen.sv
// Module: keep-mask generator.
// Produces a mask with ones in the upper W-n positions and zeros in
// the lowest n positions. Assumes n_i < W.
module dshl_mask_gen #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [SHW-1:0] n_i,
    output logic [W-1:0]   mask_o
);

    // Each bit is kept when its index is at least the shift count.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign mask_o[i] = (n_i <= SHW'(i));
    end

endmodule

// File: rtl/dshl_cr_gen.sv
// Module: condition-field builder.
// Classifies the primary result as a signed value and appends the
// overflow flag; outputs all zero when record form is off.
module dshl_cr_gen #(
    parameter int W = 64
) (
    input  logic [W-1:0]       res_i,
    input  logic               ovf_i,
    input  logic               rec_i,
    output dshl_pkg::dshl_cr_t cr_o,
    output logic               cr_we_o
);

    logic is_neg;
    logic is_zero;

    assign is_neg  = res_i[W-1];
    assign is_zero = (res_i == '0);

    // Build the field only in record form; zero it otherwise.
    always_comb begin
        cr_o    = '0;
        cr_we_o = rec_i;
        if (rec_i) begin
            cr_o.neg  = is_neg;
            cr_o.pos  = !is_neg && !is_zero;
            cr_o.zero = is_zero;
            cr_o.ovf  = ovf_i;
        end
    end

endmodule

// File: rtl/dshl_unit.sv
// Module: double-shift left datapath unit (top).
// Shifts src_i left by amt_i[SHW-1:0], fills the vacated low bits from
// fill_i, returns the pushed-out high bits in spill_o and flags a
// nonzero spill. REG_OUT=1 adds one output register stage captured on
// in_valid_i. Assumes W is a power of two.
module dshl_unit #(
    parameter int W       = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] amt_i,
    input  logic [W-1:0] fill_i,
    input  logic         rec_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] spill_o,
    output logic         ovf_o,
    output logic [3:0]   cr_o,
    output logic         cr_we_o,
    output logic         out_valid_o
);

    import dshl_pkg::*;

    localparam int SHW = $clog2(W);

    logic [SHW-1:0] n_c;
    logic [W-1:0]   rot_c;
    logic [W-1:0]   mask_c;
    logic [W-1:0]   res_c;
    logic [W-1:0]   spill_c;
    logic           ovf_c;
    dshl_cr_t       cr_c;
    logic           cr_we_c;
    logic           unused_amt_hi;

    // Only the low count bits take part; the rest are dropped here.
    assign n_c           = amt_i[SHW-1:0];
    assign unused_amt_hi = ^amt_i[W-1:SHW];

    dshl_rotator #(.W(W), .SHW(SHW)) u_rot (
        .data_i (src_i),
        .n_i    (n_c),
        .rot_o  (rot_c)
    );

    dshl_mask_gen #(.W(W), .SHW(SHW)) u_mask (
        .n_i    (n_c),
        .mask_o (mask_c)
    );

    // Split the rotated word: kept part plus fill, and the spill.
    assign res_c   = (rot_c & mask_c) | (fill_i & ~mask_c);
    assign spill_c = rot_c & ~mask_c;
    assign ovf_c   = |spill_c;

    dshl_cr_gen #(.W(W)) u_cr (
        .res_i   (res_c),
        .ovf_i   (ovf_c),
        .rec_i   (rec_i),
        .cr_o    (cr_c),
        .cr_we_o (cr_we_c)
    );

    // R5: zero count leaves the source untouched and spills nothing.
    p_zero_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (n_c == '0) |-> (res_c == src_i && spill_c == '0));

    // R3: the spill never carries bits at or above position n.
    p_spill_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_c >> n_c) == '0);

    if (REG_OUT) begin : g_reg
        logic [W-1:0] res_q;
        logic [W-1:0] spill_q;
        logic         ovf_q;
        dshl_cr_t     cr_q;
        logic         cr_we_q;
        logic         vld_q;

        // Capture all results on the input strobe; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q   <= '0;
                spill_q <= '0;
                ovf_q   <= 1'b0;
                cr_q    <= '0;
                cr_we_q <= 1'b0;
                vld_q   <= 1'b0;
            end else begin
                vld_q <= in_valid_i;
                if (in_valid_i) begin
                    res_q   <= res_c;
                    spill_q <= spill_c;
                    ovf_q   <= ovf_c;
                    cr_q    <= cr_c;
                    cr_we_q <= cr_we_c;
                end
            end
        end

        assign res_o       = res_q;
        assign spill_o     = spill_q;
        assign ovf_o       = ovf_q;
        assign cr_o        = cr_q;
        assign cr_we_o     = cr_we_q;
        assign out_valid_o = vld_q;

        // R8: a strobe yields output valid one cycle later.
        p_valid_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid_i |=> out_valid_o);

        // R8: without a strobe the data outputs hold.
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid_i |=> ($stable(res_o) && $stable(spill_o) && !out_valid_o));

        // R4: registered overflow agrees with the registered spill.
        p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_o == (spill_o != '0));

        // R6: in record form exactly one of neg/pos/zero is set.
        p_cr_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cr_we_o |-> ($countones(cr_o[3:1]) == 1 && cr_o[0] == ovf_o));

        // R7: no write-enable means an all-zero field.
        p_cr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !cr_we_o |-> (cr_o == 4'b0000));
    end else begin : g_comb
        logic unused_clk;

        assign unused_clk  = clk ^ rst_n;
        assign res_o       = res_c;
        assign spill_o     = spill_c;
        assign ovf_o       = ovf_c;
        assign cr_o        = cr_c;
        assign cr_we_o     = cr_we_c;
        assign out_valid_o = in_valid_i;
    end

endmodule

// File: tb/tb_dshl_unit.sv
// Bench: sweeps every shift count over several operand patterns with
// the output register in place and checks against arithmetic models.
module tb_dshl_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [63:0] amt = '0;
    logic [63:0] fill = '0;
    logic        rec = 1'b0;
    logic [63:0] res;
    logic [63:0] spill;
    logic        ovf;
    logic [3:0]  cr;
    logic        cr_we;
    logic        out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    dshl_unit dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .src_i       (src),
        .amt_i       (amt),
        .fill_i      (fill),
        .rec_i       (rec),
        .res_o       (res),
        .spill_o     (spill),
        .ovf_o       (ovf),
        .cr_o        (cr),
        .cr_we_o     (cr_we),
        .out_valid_o (out_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one operation and wait until its result is registered.
    task automatic issue(input logic [63:0] s, input logic [63:0] a,
                         input logic [63:0] f, input logic r);
        @(negedge clk);
        src = s; amt = a; fill = f; rec = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Compare outputs against the arithmetic model for count n.
    task automatic check_op(input logic [63:0] s, input logic [63:0] f,
                            input int n, input logic r);
        logic [63:0] e_res;
        logic [63:0] e_spill;
        logic        e_ovf;
        logic [3:0]  e_cr;
        e_res   = (s << n) | (f & ((64'd1 << n) - 64'd1));
        e_spill = (n == 0) ? 64'd0 : (s >> (64 - n));
        e_ovf   = (e_spill != 64'd0);
        e_cr    = r ? {e_res[63], !e_res[63] && e_res != 0, e_res == 0, e_ovf} : 4'b0;
        chk("R2 result (R1 count)", res, e_res);
        chk("R3 spill", spill, e_spill);
        chk("R4 overflow", {63'd0, ovf}, {63'd0, e_ovf});
        chk(r ? "R6 cr field" : "R7 cr quiet", {60'd0, cr}, {60'd0, e_cr});
        chk(r ? "R6 cr_we" : "R7 cr_we", {63'd0, cr_we}, {63'd0, r});
        chk("R8 out_valid", {63'd0, out_valid}, 64'd1);
    endtask

    function automatic logic [63:0] mix(input logic [63:0] x);
        logic [63:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        logic [63:0] seed;
        logic [63:0] held_res;
        logic [63:0] held_spill;
        seed = 64'h0123_4567_89AB_CDEF;

        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 out_valid after reset", {63'd0, out_valid}, 64'd0);
        chk("R9 res after reset", res, 64'd0);
        chk("R9 spill after reset", spill, 64'd0);
        rst_n = 1'b1;

        // Sweep all counts over fixed and pseudo-random patterns.
        for (int p = 0; p < 6; p++) begin
            for (int n = 0; n < 64; n++) begin
                logic [63:0] s, f, a;
                logic r;
                case (p)
                    0: begin s = '1;                    f = '0;                    end
                    1: begin s = 64'h8000_0000_0000_0000; f = '1;                  end
                    2: begin s = 64'hAAAA_AAAA_AAAA_AAAA; f = 64'h5555_5555_5555_5555; end
                    3: begin s = 64'h0000_0000_0000_0001; f = 64'hF0F0_F0F0_F0F0_F0F0; end
                    default: begin
                        seed = mix(seed); s = seed;
                        seed = mix(seed); f = seed;
                    end
                endcase
                seed = mix(seed);
                // R1: garbage in the upper amount bits from pattern 2 on.
                a = (p >= 2) ? {seed[63:6], 6'(n)} : 64'(n);
                r = ((n + p) % 2) == 0;
                issue(s, a, f, r);
                check_op(s, f, n, r);
                if (n == 0) begin
                    // R5: zero count returns the source unchanged.
                    chk("R5 zero count result", res, s);
                    chk("R5 zero count spill", spill, 64'd0);
                end
            end
        end

        // R6: sign classes with explicit operands.
        issue(64'h0, 64'd5, 64'h0, 1'b1);
        chk("R6 zero class", {60'd0, cr}, {60'd0, 4'b0010});
        issue(64'h1, 64'd1, 64'h0, 1'b1);
        chk("R6 positive class", {60'd0, cr}, {60'd0, 4'b0100});
        issue(64'h4000_0000_0000_0000, 64'd1, 64'h0, 1'b1);
        chk("R6 negative class", {60'd0, cr}, {60'd0, 4'b1000});
        issue(64'hC000_0000_0000_0000, 64'd1, 64'h0, 1'b1);
        chk("R6 negative with overflow", {60'd0, cr}, {60'd0, 4'b1001});

        // R1: two amounts differing only in upper bits agree.
        issue(64'h1234_5678_9ABC_DEF0, 64'd9, 64'h3FF, 1'b0);
        held_res = res;
        issue(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFC9, 64'h3FF, 1'b0);
        chk("R1 upper amount bits ignored", res, held_res);

        // R8: idle cycles with new operands hold the outputs.
        issue(64'hDEAD_BEEF_0BAD_F00D, 64'd40, 64'h77, 1'b1);
        held_res   = res;
        held_spill = spill;
        @(negedge clk);
        src = '1; amt = 64'd3; fill = '1;
        @(negedge clk);
        chk("R8 res holds while idle", res, held_res);
        chk("R8 spill holds while idle", spill, held_spill);
        chk("R8 out_valid low while idle", {63'd0, out_valid}, 64'd0);

        // R10: chained 128-bit shift.
        for (int n = 1; n < 64; n += 7) begin
            logic [63:0] lo, hi, fin, lo_r, hi_r, top;
            logic [127:0] full, e_full;
            seed = mix(seed); lo = seed;
            seed = mix(seed); hi = seed;
            seed = mix(seed); fin = seed;
            full   = {hi, lo};
            e_full = (full << n) | {64'd0, fin & ((64'd1 << n) - 64'd1)};
            issue(lo, 64'(n), fin, 1'b0);
            lo_r = res;
            issue(hi, 64'(n), spill, 1'b0);
            hi_r = res;
            top  = spill;
            chk("R10 chained low word", lo_r, e_full[63:0]);
            chk("R10 chained high word", hi_r, e_full[127:64]);
            chk("R10 chained spill", top, hi >> (64 - n));
        end

        // R9: reset in mid-run clears the valid flag and outputs.
        issue(64'hFFFF, 64'd4, 64'h0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R9 valid cleared by reset", {63'd0, out_valid}, 64'd0);
        chk("R9 res cleared by reset", res, 64'd0);
        in_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule